// File: doc/BRIEF.md
# ULPI Serial-Mode Data Bus Mapper

This block sits between the eight data pins of a ULPI-style link bus and the rest of a transceiver. In normal operation it passes the bus straight to an external packet path, which decides on its own whether the pins are driven. When the link selects a full/low-speed serial mode, the block takes over the pins. Each pin then gets a fixed role: a line-side transmit control input, a receive status output, the interrupt flag, or a constant low. Each data pin has its own output-enable bit, so the pad ring can turn the direction of every pin separately.

Two serial maps are supported. The 6-pin map uses three dedicated transmit inputs and four outputs. The 3-pin map shares its data and SE0 pins between both directions. Those two pins become receive outputs whenever the transmit-enable pin is low, so their direction changes within the cycle and follows the link. A serial mode starts one clock after the register block writes the matching control bit. A serial mode ends when the link raises STP. The block then reports the exit, so that the register block clears its mode bits, and it releases every pin for one cycle before the packet path drives again. An interrupt flag is set from a masked event vector and held until it is read-cleared. In both serial maps it is presented on pin 3.

Top module: `ulpi_serial_mux`

## Requirements
- R1: While and just after reset, the mapper is in normal mode (`mode_ser6` and `mode_ser3` low) and `irq_flag` is low.
- R2: In normal mode every `d_oe` bit equals `pkt_oe`, `d_out` equals `pkt_d_out`, and `tx_en`, `tx_dat` and `tx_se0` are low. `pkt_d_in` always equals `d_in`.
- R3: A pulse on `wr_ser6` selects 6-pin mode from the next clock edge, and a pulse on `wr_ser3` selects 3-pin mode. If both pulse together, 3-pin mode is chosen. A write in a serial mode switches the map unless STP is raised in the same cycle.
- R4: In 6-pin mode, pins 0, 1 and 2 are inputs (`d_oe[2:0]` = 0), and `tx_en`, `tx_dat` and `tx_se0` follow `d_in[0]`, `d_in[1]` and `d_in[2]`.
- R5: In 6-pin mode, pins 7..3 are driven (`d_oe[7:3]` all 1). Pin 3 carries `irq_flag`, pin 4 `rx_dp`, pin 5 `rx_dm`, pin 6 `rx_rcv`, and pin 7 is 0.
- R6: In 3-pin mode, pin 0 is an input that drives `tx_en`. Pin 3 is driven with `irq_flag`, and pins 7..4 are driven 0.
- R7: In 3-pin mode with `d_in[0]` high, pins 1 and 2 are inputs, and `tx_dat` = `d_in[1]`, `tx_se0` = `d_in[2]`. With `d_in[0]` low, pin 1 drives `rx_rcv`, pin 2 drives the received SE0 (`rx_dp` and `rx_dm` both 0), and `tx_dat` and `tx_se0` are 0.
- R8: STP in a serial mode raises `ser_exit` in the same cycle. In the next cycle every `d_oe` bit is 0, the transmit outputs are 0 and both mode flags are low. Normal mode follows, unless a mode write arrives during that cycle. STP in normal mode has no effect.
- R9: `irq_flag` is set at the clock edge after a cycle in which `irq_evt & irq_mask` is non-zero. Events whose mask bit is 0 do not set it.
- R10: `irq_clr` clears `irq_flag` at the next edge, unless an unmasked event is present in the same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stp | input | 1 | Link stop signal |
| wr_ser6 | input | 1 | Write-one pulse of the 6-pin serial control bit |
| wr_ser3 | input | 1 | Write-one pulse of the 3-pin serial control bit |
| d_in | input | 8 | Data pin input values from the pads |
| d_out | output | 8 | Data pin output values to the pads |
| d_oe | output | 8 | Per-pin output enable |
| pkt_d_out | input | 8 | Normal-mode data from the packet path |
| pkt_oe | input | 1 | Normal-mode bus drive request |
| pkt_d_in | output | 8 | Bus input data to the packet path |
| tx_en | output | 1 | Line transmit enable |
| tx_dat | output | 1 | Line transmit differential data |
| tx_se0 | output | 1 | Line transmit single-ended zero |
| rx_dp | input | 1 | Single-ended receive from DP |
| rx_dm | input | 1 | Single-ended receive from DM |
| rx_rcv | input | 1 | Differential receive data |
| irq_evt | input | 8 | Interrupt event vector |
| irq_mask | input | 8 | Interrupt enable mask |
| irq_clr | input | 1 | Read-clear strobe of the interrupt flag |
| irq_flag | output | 1 | Latched interrupt flag |
| mode_ser6 | output | 1 | 6-pin serial mode active |
| mode_ser3 | output | 1 | 3-pin serial mode active |
| ser_exit | output | 1 | Serial-mode exit; clears the control bits |

## Verification
The bench checks the 3-pin map in both states of pin 0. A mapper that latched the direction of pin 0 instead of following it would contend with the link for one cycle, or would miss a receive cycle. It applies STP together with a mode write, and writes of both control bits together. Wrong priority would then either stay in serial mode or select the 6-pin map. It checks the one released cycle after exit. A design that skipped it would drive packet data straight into a pin the link still owns. It also raises clear and an event together; a design with the wrong priority would lose that interrupt.

// File: rtl/ulpi_serial_pkg.sv
package ulpi_serial_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_SER6   = 2'd1,
    MD_SER3   = 2'd2,
    MD_DRAIN  = 2'd3
  } bus_mode_e;

  typedef enum logic [3:0] {
    PR_PKT, PR_IN, PR_LOW, PR_IRQ, PR_DP, PR_DM, PR_RCV, PR_SE0, PR_FLOAT
  } pin_role_e;

  localparam int unsigned PIN_TXEN = 0;
  localparam int unsigned PIN_DAT  = 1;
  localparam int unsigned PIN_SE0  = 2;
  localparam int unsigned PIN_IRQ  = 3;
  localparam int unsigned PIN_DP   = 4;
  localparam int unsigned PIN_DM   = 5;
  localparam int unsigned PIN_RCV  = 6;

  function automatic pin_role_e pin_role(bus_mode_e m, int unsigned idx, logic txen);
    pin_role_e r;
    r = PR_LOW;
    case (m)
      MD_NORMAL: r = PR_PKT;
      MD_DRAIN:  r = PR_FLOAT;
      MD_SER6: begin
        if (idx <= PIN_SE0)      r = PR_IN;
        else if (idx == PIN_IRQ) r = PR_IRQ;
        else if (idx == PIN_DP)  r = PR_DP;
        else if (idx == PIN_DM)  r = PR_DM;
        else if (idx == PIN_RCV) r = PR_RCV;
        else                     r = PR_LOW;
      end
      MD_SER3: begin
        if (idx == PIN_TXEN)     r = PR_IN;
        else if (idx == PIN_DAT) r = txen ? PR_IN : PR_RCV;
        else if (idx == PIN_SE0) r = txen ? PR_IN : PR_SE0;
        else if (idx == PIN_IRQ) r = PR_IRQ;
        else                     r = PR_LOW;
      end
      default: r = PR_FLOAT;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ulpi_mode_fsm.sv
module ulpi_mode_fsm
  import ulpi_serial_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stp,
  input  logic      wr_ser6,
  input  logic      wr_ser3,
  output bus_mode_e mode,
  output logic      exit_pulse
);

  bus_mode_e mode_q, mode_d;
  logic      mode_en;
  logic      in_serial;

  assign in_serial  = (mode_q == MD_SER6) || (mode_q == MD_SER3);
  assign exit_pulse = stp && in_serial;

  always_comb begin
    mode_d = mode_q;
    if (exit_pulse)   mode_d = MD_DRAIN;
    else if (wr_ser3) mode_d = MD_SER3;
    else if (wr_ser6) mode_d = MD_SER6;
    else if (!in_serial) mode_d = MD_NORMAL;
  end

  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_NORMAL;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R8
  drain_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_DRAIN && !wr_ser3 && !wr_ser6) |=> (mode_q == MD_NORMAL));

  // R3
  both_writes_pick_ser3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ser3 && wr_ser6 && !exit_pulse) |=> (mode_q == MD_SER3));

endmodule

// File: rtl/ulpi_irq_latch.sv
module ulpi_irq_latch #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic [IRQ_W-1:0] mask,
  input  logic             clr,
  output logic             flag
);

  logic flag_q, flag_d, flag_en;
  logic hit;

  assign hit     = |(evt & mask);
  assign flag_d  = hit | (flag_q & ~clr);
  assign flag_en = hit | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R9
  irq_sets_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R10
  irq_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);

  // R9
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/ulpi_pin_map.sv
module ulpi_pin_map
  import ulpi_serial_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  bus_mode_e        mode,
  input  logic [BUS_W-1:0] d_in,
  input  logic [BUS_W-1:0] pkt_d_out,
  input  logic             pkt_oe,
  input  logic             irq_flag,
  input  logic             rx_dp,
  input  logic             rx_dm,
  input  logic             rx_rcv,
  output logic [BUS_W-1:0] d_out,
  output logic [BUS_W-1:0] d_oe,
  output logic             tx_en,
  output logic             tx_dat,
  output logic             tx_se0
);

  logic rx_se0;
  logic link_tx;

  assign rx_se0  = ~rx_dp & ~rx_dm;
  assign link_tx = d_in[PIN_TXEN];

  for (genvar i = 0; i < BUS_W; i++) begin : g_pin
    pin_role_e role;
    assign role = pin_role(mode, i, link_tx);
    always_comb begin
      d_out[i] = 1'b0;
      d_oe[i]  = 1'b0;
      case (role)
        PR_PKT:   begin d_out[i] = pkt_d_out[i]; d_oe[i] = pkt_oe; end
        PR_IN:    begin d_out[i] = 1'b0;         d_oe[i] = 1'b0;   end
        PR_LOW:   begin d_out[i] = 1'b0;         d_oe[i] = 1'b1;   end
        PR_IRQ:   begin d_out[i] = irq_flag;     d_oe[i] = 1'b1;   end
        PR_DP:    begin d_out[i] = rx_dp;        d_oe[i] = 1'b1;   end
        PR_DM:    begin d_out[i] = rx_dm;        d_oe[i] = 1'b1;   end
        PR_RCV:   begin d_out[i] = rx_rcv;       d_oe[i] = 1'b1;   end
        PR_SE0:   begin d_out[i] = rx_se0;       d_oe[i] = 1'b1;   end
        default:  begin d_out[i] = 1'b0;         d_oe[i] = 1'b0;   end
      endcase
    end
  end

  always_comb begin
    tx_en  = 1'b0;
    tx_dat = 1'b0;
    tx_se0 = 1'b0;
    case (mode)
      MD_SER6: begin
        tx_en  = d_in[PIN_TXEN];
        tx_dat = d_in[PIN_DAT];
        tx_se0 = d_in[PIN_SE0];
      end
      MD_SER3: begin
        tx_en  = link_tx;
        tx_dat = link_tx & d_in[PIN_DAT];
        tx_se0 = link_tx & d_in[PIN_SE0];
      end
      default: begin
        tx_en  = 1'b0;
        tx_dat = 1'b0;
        tx_se0 = 1'b0;
      end
    endcase
  end

  // R7
  always_comb begin
    if (mode == MD_SER3 && link_tx)
      ser3_no_contention_chk: assert (d_oe[PIN_SE0:PIN_DAT] == 2'b00);
  end

endmodule

// File: rtl/ulpi_serial_mux.sv
module ulpi_serial_mux
  import ulpi_serial_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stp,
  input  logic             wr_ser6,
  input  logic             wr_ser3,
  input  logic [BUS_W-1:0] d_in,
  output logic [BUS_W-1:0] d_out,
  output logic [BUS_W-1:0] d_oe,
  input  logic [BUS_W-1:0] pkt_d_out,
  input  logic             pkt_oe,
  output logic [BUS_W-1:0] pkt_d_in,
  output logic             tx_en,
  output logic             tx_dat,
  output logic             tx_se0,
  input  logic             rx_dp,
  input  logic             rx_dm,
  input  logic             rx_rcv,
  input  logic [IRQ_W-1:0] irq_evt,
  input  logic [IRQ_W-1:0] irq_mask,
  input  logic             irq_clr,
  output logic             irq_flag,
  output logic             mode_ser6,
  output logic             mode_ser3,
  output logic             ser_exit
);

  bus_mode_e mode;
  logic      flag;
  logic      past_ok_q;

  ulpi_mode_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stp        (stp),
    .wr_ser6    (wr_ser6),
    .wr_ser3    (wr_ser3),
    .mode       (mode),
    .exit_pulse (ser_exit)
  );

  ulpi_irq_latch #(.IRQ_W(IRQ_W)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (irq_evt),
    .mask  (irq_mask),
    .clr   (irq_clr),
    .flag  (flag)
  );

  ulpi_pin_map #(.BUS_W(BUS_W)) i_map (
    .mode      (mode),
    .d_in      (d_in),
    .pkt_d_out (pkt_d_out),
    .pkt_oe    (pkt_oe),
    .irq_flag  (flag),
    .rx_dp     (rx_dp),
    .rx_dm     (rx_dm),
    .rx_rcv    (rx_rcv),
    .d_out     (d_out),
    .d_oe      (d_oe),
    .tx_en     (tx_en),
    .tx_dat    (tx_dat),
    .tx_se0    (tx_se0)
  );

  assign pkt_d_in  = d_in;
  assign irq_flag  = flag;
  assign mode_ser6 = (mode == MD_SER6);
  assign mode_ser3 = (mode == MD_SER3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // R8
  exit_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(ser_exit)) |-> (d_oe == '0 && !tx_en && !mode_ser6 && !mode_ser3));

  // R3
  ser3_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $past(wr_ser3) && !$past(ser_exit)) |-> mode_ser3);

  // R5
  ser6_irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ser6 |-> (d_oe[PIN_IRQ] && d_out[PIN_IRQ] == irq_flag && !d_out[BUS_W-1]));

  // R7
  ser3_rx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ser3 && !d_in[PIN_TXEN]) |-> (d_oe[PIN_DAT] && d_out[PIN_DAT] == rx_rcv));

  // R8
  stp_normal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ser6 && !mode_ser3 && stp && !wr_ser6 && !wr_ser3) |=> (!mode_ser6 && !mode_ser3));

endmodule

// File: tb/test_ulpi_serial_mux.sv
module test_ulpi_serial_mux;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stp, wr_ser6, wr_ser3;
  logic [7:0] d_in, d_out, d_oe, pkt_d_out, pkt_d_in;
  logic       pkt_oe, tx_en, tx_dat, tx_se0;
  logic       rx_dp, rx_dm, rx_rcv;
  logic [7:0] irq_evt, irq_mask;
  logic       irq_clr, irq_flag, mode_ser6, mode_ser3, ser_exit;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference state: 0 normal, 1 six-pin, 2 three-pin, 3 released cycle
  int rm;
  bit rflag;

  always #4 clk = ~clk;

  ulpi_serial_mux i_ulpi_serial_mux (
    .clk(clk), .rst_n(rst_n), .stp(stp), .wr_ser6(wr_ser6), .wr_ser3(wr_ser3),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .pkt_d_out(pkt_d_out), .pkt_oe(pkt_oe),
    .pkt_d_in(pkt_d_in), .tx_en(tx_en), .tx_dat(tx_dat), .tx_se0(tx_se0),
    .rx_dp(rx_dp), .rx_dm(rx_dm), .rx_rcv(rx_rcv), .irq_evt(irq_evt),
    .irq_mask(irq_mask), .irq_clr(irq_clr), .irq_flag(irq_flag),
    .mode_ser6(mode_ser6), .mode_ser3(mode_ser3), .ser_exit(ser_exit)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic quiet();
    stp = 0; wr_ser6 = 0; wr_ser3 = 0; irq_clr = 0;
    irq_evt = 0;
  endtask

  // compare current outputs against the model, then advance the model one edge
  task automatic tick();
    logic [7:0] eoe, eout;
    logic [2:0] etx;
    bit d0, se0, ex;
    string rq;
    #2;
    d0  = d_in[0];
    se0 = !rx_dp && !rx_dm;
    eoe = 8'h00; eout = 8'h00; etx = 3'b000; rq = "R2";
    case (rm)
      0: begin eoe = pkt_oe ? 8'hFF : 8'h00; eout = pkt_d_out; rq = "R2"; end
      1: begin
        eoe = 8'hF8; eout = {1'b0, rx_rcv, rx_dm, rx_dp, rflag, 3'b000};
        etx = {d_in[0], d_in[1], d_in[2]}; rq = "R4_R5";
      end
      2: begin
        eoe  = d0 ? 8'hF8 : 8'hFE;
        eout = {4'b0000, rflag, d0 ? 1'b0 : se0, d0 ? 1'b0 : rx_rcv, 1'b0};
        etx  = {d0, d0 & d_in[1], d0 & d_in[2]}; rq = "R6_R7";
      end
      default: begin eoe = 8'h00; rq = "R8"; end
    endcase
    chk(rq, "d_oe", {24'd0, d_oe}, {24'd0, eoe});
    chk(rq, "d_out", {24'd0, d_out & eoe}, {24'd0, eout & eoe});
    chk(rq, "tx", {29'd0, tx_en, tx_dat, tx_se0}, {29'd0, etx});
    chk("R2", "pkt_d_in", {24'd0, pkt_d_in}, {24'd0, d_in});
    chk("R3", "mode flags", {30'd0, mode_ser6, mode_ser3}, {30'd0, rm == 1, rm == 2});
    chk("R9_R10", "irq_flag", {31'd0, irq_flag}, {31'd0, rflag});
    ex = stp && (rm == 1 || rm == 2);
    chk("R8", "ser_exit", {31'd0, ser_exit}, {31'd0, ex});
    if (ex)           rm = 3;
    else if (wr_ser3) rm = 2;
    else if (wr_ser6) rm = 1;
    else if (rm == 3) rm = 0;
    rflag = (|(irq_evt & irq_mask)) | (rflag & !irq_clr);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 0; quiet();
    d_in = 0; pkt_d_out = 8'hA5; pkt_oe = 0; rx_dp = 0; rx_dm = 0; rx_rcv = 0;
    irq_mask = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode flags in reset", {30'd0, mode_ser6, mode_ser3}, 32'd0);
    chk("R1", "irq_flag in reset", {31'd0, irq_flag}, 32'd0);
    rst_n = 1;
    rm = 0; rflag = 0;
    @(negedge clk);
    chk("R1", "mode flags after reset", {30'd0, mode_ser6, mode_ser3}, 32'd0);

    // R2 normal passthrough, with drive on and off
    pkt_oe = 1; d_in = 8'h3C; tick();
    pkt_oe = 0; pkt_d_out = 8'h5A; tick();
    // R8 STP in normal mode ignored
    stp = 1; tick(); quiet(); tick();
    // R3 enter 6-pin, R4/R5 patterns
    wr_ser6 = 1; tick(); quiet();
    d_in = 8'h05; rx_dp = 1; rx_dm = 0; rx_rcv = 1; tick();
    d_in = 8'h02; rx_dp = 0; rx_dm = 1; rx_rcv = 0; tick();
    // R9 masked event ignored, unmasked sets
    irq_mask = 8'h0F; irq_evt = 8'hF0; tick(); quiet(); tick();
    irq_evt = 8'h04; tick(); quiet(); tick();
    // R10 clear with simultaneous event keeps flag, clear alone drops it
    irq_clr = 1; irq_evt = 8'h01; tick(); quiet(); tick();
    irq_clr = 1; tick(); quiet(); tick();
    // R8 STP with a write in the same cycle: STP wins, one released cycle
    stp = 1; wr_ser3 = 1; pkt_oe = 1; tick(); quiet(); tick(); tick();
    // R3 both bits together pick 3-pin mode
    wr_ser6 = 1; wr_ser3 = 1; tick(); quiet();
    // R6/R7 with pin 0 high, then low, with SE0 and J states
    d_in = 8'h07; tick();
    d_in = 8'h06; rx_dp = 0; rx_dm = 0; rx_rcv = 1; tick();
    d_in = 8'h00; rx_dp = 1; rx_dm = 0; rx_rcv = 0; tick();
    irq_evt = 8'h08; tick(); quiet(); tick();
    // R3 switch from 3-pin to 6-pin while serial
    wr_ser6 = 1; tick(); quiet(); tick();
    stp = 1; tick(); quiet(); tick(); tick();

    // mixed stimulus
    for (int n = 0; n < 6000; n++) begin
      stp       = ($urandom_range(0, 15) == 0);
      wr_ser6   = ($urandom_range(0, 19) == 0);
      wr_ser3   = ($urandom_range(0, 19) == 0);
      irq_clr   = ($urandom_range(0, 7) == 0);
      irq_evt   = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
      irq_mask  = 8'($urandom);
      d_in      = 8'($urandom);
      pkt_d_out = 8'($urandom);
      pkt_oe    = 1'($urandom);
      rx_dp     = 1'($urandom);
      rx_dm     = 1'($urandom);
      rx_rcv    = 1'($urandom);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule